// File: doc/BRIEF.md
# Subframe ID Synchronizer

This block sits behind a frame synchronizer that already delivers parallel PCM words with a word index and a frame-start flag. In every minor frame it picks out the word at a configured index, masks it down to the bits that carry the subframe counter, and tracks that counter over successive frames. When enough frames in a row carry IDs that step forward by one, it declares subframe lock. From then on it reports the current subframe number, so that downstream extraction logic can tell which subframe each parameter word belongs to.

While locked, the block runs its own subframe counter. The counter advances once per frame and wraps at the configured subframe count. The received ID is only compared against this counter. A single disagreement moves the block into a checking state and leaves the subframe number valid. Several disagreements in a row drop it back to search. A frame whose ID word never arrives counts as a disagreement. When the frame-lock input falls, subframe acquisition starts again from scratch.

Top module: `subframe_id_sync`

## Requirements
- R1: After reset, `sync_state` is 0 (search), `sub_locked` is 0 and `sub_num` is 0. The state codes are: 0 = search, 1 = check, 2 = locked. Code 3 never appears.
- R2: The ID is `word_data & cfg_id_mask`, taken only from a word with `word_valid`=1 and `word_idx`=`cfg_id_pos`. Other words and bits outside the mask have no effect.
- R3: In search, the block locks on the clock edge that captures the third ID in an unbroken run where each ID equals the previous ID plus one. At that edge `sync_state` becomes 2, `sub_locked` becomes 1 and `sub_num` takes the value of that third ID.
- R4: The step from `cfg_sub_count`−1 to 0 counts as consecutive, both while acquiring and while locked.
- R5: A masked ID at or above `cfg_sub_count` is invalid. In search it clears the run. In lock or check it counts as a mismatch. While locked, `sub_num` stays below `cfg_sub_count`.
- R6: In lock or check, each ID event advances `sub_num` by one, modulo `cfg_sub_count`, whatever ID value was received.
- R7: In lock, one mismatching ID moves the block to check (state 1), with `sub_locked` still 1. In check, a matching ID returns it to lock.
- R8: Three mismatches in a row, counting the one that left lock, return the block to search with `sub_locked`=0.
- R9: The block notes a missing ID when a frame start arrives, that frame start is not itself the ID word, and the previous frame carried no ID word. The missing ID is then a mismatch in lock or check, and clears the acquisition run in search.
- R10: While `frame_locked` is 0, the block goes to search on the next edge and its acquisition run is cleared.
- R11: While locked, `sub_num` changes only on an edge where a valid word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_locked | input | 1 | Frame synchronizer reports lock |
| word_valid | input | 1 | A word is presented this cycle |
| frame_start | input | 1 | Presented word is the first of a minor frame |
| word_idx | input | IDX_W | Position of the presented word in its frame |
| word_data | input | WORD_W | Presented word |
| cfg_id_pos | input | IDX_W | Word position holding the subframe ID |
| cfg_id_mask | input | WORD_W | Bits of the ID word that carry the counter |
| cfg_sub_count | input | SUB_W | Number of subframes (at least 2) |
| sub_locked | output | 1 | Subframe number valid (lock or check) |
| sync_state | output | 2 | 0 search, 1 check, 2 locked |
| sub_num | output | SUB_W | Current subframe number |

## Verification
The bench goes after these corner cases:

- **Wrap from the last subframe to 0.** A design that compares without the modulo would lose lock once per major frame.
- **Out-of-range IDs below the mask limit.** A design that skips the range check would lock on garbage.
- **A frame whose ID word is dropped.** A design that ignores it would let its counter fall one subframe behind.
- **Garbage above the mask.** A design that compares the raw word would never lock.
- **The exact number of bad frames needed to lose lock, and frame-lock loss in the middle of a run.** Off-by-one counters or stale run state would show up as an early or late state change.

// File: rtl/sfid_pkg.sv
package sfid_pkg;
    typedef enum logic [1:0] {
        SF_SEARCH = 2'd0,
        SF_CHECK  = 2'd1,
        SF_LOCK   = 2'd2
    } sf_state_e;
endpackage

// File: rtl/sfid_id_pick.sv
// Selects the ID word of a frame and strips bits outside the counter mask.
module sfid_id_pick #(
    parameter int WORD_W = 12,
    parameter int IDX_W  = 8
) (
    input  logic              word_valid,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] word_data,
    input  logic [IDX_W-1:0]  cfg_id_pos,
    input  logic [WORD_W-1:0] cfg_id_mask,
    output logic              capture,
    output logic [WORD_W-1:0] id_value
);
    always_comb begin
        capture  = word_valid && (word_idx == cfg_id_pos);
        id_value = word_data & cfg_id_mask;
    end
endmodule

// File: rtl/sfid_mod_inc.sv
// Increment modulo a run-time count.
module sfid_mod_inc #(
    parameter int W = 6
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] count,
    output logic [W-1:0] next
);
    always_comb begin
        if (value == count - W'(1))
            next = '0;
        else
            next = value + W'(1);
    end
endmodule

// File: rtl/sfid_frame_watch.sv
// Flags a frame boundary that closes a frame without an ID word.
module sfid_frame_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_locked,
    input  logic word_valid,
    input  logic frame_start,
    input  logic capture,
    output logic missing
);
    typedef struct packed {
        logic started;
        logic seen;
    } watch_t;

    watch_t watch_d, watch_q;

    always_comb begin
        watch_d = watch_q;
        if (!frame_locked) begin
            watch_d = '0;
        end else if (word_valid && frame_start) begin
            watch_d.started = 1'b1;
            watch_d.seen    = capture;
        end else if (capture) begin
            watch_d.seen = 1'b1;
        end
        missing = frame_locked && word_valid && frame_start &&
                  watch_q.started && !watch_q.seen && !capture;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            watch_q <= '0;
        else
            watch_q <= watch_d;
    end
endmodule

// File: rtl/subframe_id_sync.sv
module subframe_id_sync
    import sfid_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int IDX_W     = 8,
    parameter int SUB_W     = 6,
    parameter int LOCK_RUN  = 3,
    parameter int LOSS_BAD  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_locked,
    input  logic              word_valid,
    input  logic              frame_start,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] word_data,
    input  logic [IDX_W-1:0]  cfg_id_pos,
    input  logic [WORD_W-1:0] cfg_id_mask,
    input  logic [SUB_W-1:0]  cfg_sub_count,
    output logic              sub_locked,
    output logic [1:0]        sync_state,
    output logic [SUB_W-1:0]  sub_num
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam int BAD_W = $clog2(LOSS_BAD + 1);

    typedef struct packed {
        sf_state_e          state;
        logic [RUN_W-1:0]   run;
        logic [SUB_W-1:0]   prev;
        logic [SUB_W-1:0]   sub;
        logic [BAD_W-1:0]   bad;
    } core_t;

    core_t core_d, core_q;

    logic              capture;
    logic              missing;
    logic [WORD_W-1:0] id_value;
    logic [SUB_W-1:0]  id_sub;
    logic              in_range;
    logic [SUB_W-1:0]  prev_next;
    logic [SUB_W-1:0]  sub_next;
    logic              id_good;

    sfid_id_pick #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_pick (
        .word_valid (word_valid),
        .word_idx   (word_idx),
        .word_data  (word_data),
        .cfg_id_pos (cfg_id_pos),
        .cfg_id_mask(cfg_id_mask),
        .capture    (capture),
        .id_value   (id_value)
    );

    sfid_frame_watch u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_locked(frame_locked),
        .word_valid  (word_valid),
        .frame_start (frame_start),
        .capture     (capture),
        .missing     (missing)
    );

    sfid_mod_inc #(.W(SUB_W)) u_prev_inc (
        .value(core_q.prev),
        .count(cfg_sub_count),
        .next (prev_next)
    );

    sfid_mod_inc #(.W(SUB_W)) u_sub_inc (
        .value(core_q.sub),
        .count(cfg_sub_count),
        .next (sub_next)
    );

    always_comb begin
        in_range = id_value < WORD_W'(cfg_sub_count);
        id_sub   = id_value[SUB_W-1:0];
        id_good  = capture && in_range && (id_sub == sub_next);

        core_d = core_q;
        if (!frame_locked) begin
            core_d.state = SF_SEARCH;
            core_d.run   = '0;
            core_d.bad   = '0;
        end else if (capture || missing) begin
            unique case (core_q.state)
                SF_SEARCH: begin
                    if (missing || !in_range) begin
                        core_d.run = '0;
                    end else if (core_q.run == '0) begin
                        core_d.run  = RUN_W'(1);
                        core_d.prev = id_sub;
                    end else if (id_sub == prev_next) begin
                        if (core_q.run >= RUN_W'(LOCK_RUN - 1)) begin
                            core_d.state = SF_LOCK;
                            core_d.sub   = id_sub;
                            core_d.run   = '0;
                            core_d.bad   = '0;
                        end else begin
                            core_d.run  = core_q.run + RUN_W'(1);
                            core_d.prev = id_sub;
                        end
                    end else begin
                        core_d.run  = RUN_W'(1);
                        core_d.prev = id_sub;
                    end
                end
                SF_LOCK: begin
                    core_d.sub = sub_next;
                    if (!id_good) begin
                        core_d.state = SF_CHECK;
                        core_d.bad   = BAD_W'(1);
                    end
                end
                SF_CHECK: begin
                    core_d.sub = sub_next;
                    if (id_good) begin
                        core_d.state = SF_LOCK;
                        core_d.bad   = '0;
                    end else if (core_q.bad >= BAD_W'(LOSS_BAD - 1)) begin
                        core_d.state = SF_SEARCH;
                        core_d.bad   = '0;
                        core_d.run   = '0;
                    end else begin
                        core_d.bad = core_q.bad + BAD_W'(1);
                    end
                end
                default: core_d.state = SF_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q.state <= SF_SEARCH;
            core_q.run   <= '0;
            core_q.prev  <= '0;
            core_q.sub   <= '0;
            core_q.bad   <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign sync_state = core_q.state;
    assign sub_locked = (core_q.state == SF_LOCK) || (core_q.state == SF_CHECK);
    assign sub_num    = core_q.sub;
endmodule

// File: rtl/subframe_id_sync_chk.sv
module subframe_id_sync_chk #(
    parameter int IDX_W = 8,
    parameter int SUB_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_locked,
    input logic             word_valid,
    input logic [IDX_W-1:0] word_idx,
    input logic [IDX_W-1:0] cfg_id_pos,
    input logic [SUB_W-1:0] cfg_sub_count,
    input logic             sub_locked,
    input logic [1:0]       sync_state,
    input logic [SUB_W-1:0] sub_num
);
    logic             id_strobe;
    logic [SUB_W-1:0] exp_next;

    assign id_strobe = word_valid && (word_idx == cfg_id_pos);
    assign exp_next  = (sub_num == cfg_sub_count - SUB_W'(1)) ? '0 : sub_num + SUB_W'(1);

    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        sync_state != 2'd3);

    a_r10_frame_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_locked |=> sync_state == 2'd0);

    a_r3_lock_on_id: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_locked) |-> $past(id_strobe && frame_locked));

    a_r5_num_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sub_locked |-> sub_num < cfg_sub_count);

    a_r6_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_locked && frame_locked && id_strobe) |=> (!sub_locked || sub_num == $past(exp_next)));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_locked && !word_valid) |=> (!sub_locked || $stable(sub_num)));

    a_r8_loss_from_check: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sub_locked) && $past(frame_locked)) |-> $past(sync_state) == 2'd1);
endmodule

bind subframe_id_sync subframe_id_sync_chk #(.IDX_W(IDX_W), .SUB_W(SUB_W)) u_chk (.*);

// File: tb/subframe_id_sync_tb_top.sv
module subframe_id_sync_tb_top;
    localparam int WORD_W = 12;
    localparam int IDX_W  = 8;
    localparam int SUB_W  = 6;
    localparam int FLEN   = 6;
    localparam int IDPOS  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_locked = 1'b0;
    logic              word_valid = 1'b0;
    logic              frame_start = 1'b0;
    logic [IDX_W-1:0]  word_idx = '0;
    logic [WORD_W-1:0] word_data = '0;
    logic [IDX_W-1:0]  cfg_id_pos = IDX_W'(IDPOS);
    logic [WORD_W-1:0] cfg_id_mask = 12'h03F;
    logic [SUB_W-1:0]  cfg_sub_count = 6'd12;
    logic              sub_locked;
    logic [1:0]        sync_state;
    logic [SUB_W-1:0]  sub_num;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference state
    int m_state, m_run, m_prev, m_sub, m_bad;
    bit m_started, m_seen;

    always #4 clk = ~clk;

    subframe_id_sync dut_i (.*);

    function automatic int nxt(int v, int cnt);
        return (v == cnt - 1) ? 0 : v + 1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic m_reset();
        m_state = 0; m_run = 0; m_bad = 0; m_started = 0; m_seen = 0;
    endtask

    // applies one presented cycle to the reference
    task automatic m_step(bit v, bit fs, int idx, int data);
        int cnt, id;
        bit cap, miss, good;
        cnt  = int'(cfg_sub_count);
        cap  = v && (idx == IDPOS);
        miss = v && fs && m_started && !m_seen && !cap;
        id   = data & int'(cfg_id_mask);
        if (!frame_locked) begin
            m_state = 0; m_run = 0; m_bad = 0; m_started = 0; m_seen = 0;
            return;
        end
        if (cap || miss) begin
            good = cap && id < cnt && id == nxt(m_sub, cnt);
            case (m_state)
                0: begin
                    if (miss || id >= cnt) m_run = 0;
                    else if (m_run == 0) begin m_run = 1; m_prev = id; end
                    else if (id == nxt(m_prev, cnt)) begin
                        if (m_run == 2) begin m_state = 2; m_sub = id; m_run = 0; m_bad = 0; end
                        else begin m_run++; m_prev = id; end
                    end else begin m_run = 1; m_prev = id; end
                end
                2: begin
                    m_sub = nxt(m_sub, cnt);
                    if (!good) begin m_state = 1; m_bad = 1; end
                end
                default: begin
                    m_sub = nxt(m_sub, cnt);
                    if (good) begin m_state = 2; m_bad = 0; end
                    else if (m_bad == 2) begin m_state = 0; m_bad = 0; m_run = 0; end
                    else m_bad++;
                end
            endcase
        end
        if (v && fs) begin m_started = 1; m_seen = cap; end
        else if (cap) m_seen = 1;
    endtask

    task automatic drive(bit v, bit fs, int idx, int data);
        @(negedge clk);
        word_valid  = v;
        frame_start = fs;
        word_idx    = IDX_W'(idx);
        word_data   = WORD_W'(data);
        m_step(v, fs, idx, data);
    endtask

    task automatic send_frame(int id, bit has_id);
        for (int w = 0; w < FLEN; w++) begin
            if (w == IDPOS) begin
                if (has_id) drive(1, w == 0, w, (id & 'h3F) | (int'($urandom) & 'hFC0));
                else drive(0, 0, 0, 0);
            end else begin
                drive(1, w == 0, w, int'($urandom) & 'hFFF);
            end
            if ($urandom % 4 == 0) drive(0, 0, 0, int'($urandom) & 'hFFF);
        end
        drive(0, 0, 0, 0);
        @(negedge clk);
    endtask

    task automatic check_all(string req);
        check({req, " state"}, int'(sync_state), m_state);
        check({req, " locked"}, int'(sub_locked), int'(m_state != 0));
        if (m_state != 0) check({req, " sub_num"}, int'(sub_num), m_sub);
    endtask

    task automatic drop_frame_lock();
        @(negedge clk);
        frame_locked = 1'b0;
        word_valid = 1'b0;
        m_step(0, 0, 0, 0);
        @(negedge clk);
        check("R10 drop", int'(sync_state), 0);
        check("R10 unlocked", int'(sub_locked), 0);
        frame_locked = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int tx;
        void'($urandom(32'h5EED_1234));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 state", int'(sync_state), 0);
        check("R1 locked", int'(sub_locked), 0);
        check("R1 sub_num", int'(sub_num), 0);
        frame_locked = 1'b1;

        // R3 acquisition, R2 garbage above mask
        send_frame(5, 1); check_all("R3 first");
        send_frame(6, 1); check_all("R3 second");
        check("R3 not yet", int'(sub_locked), 0);
        send_frame(7, 1); check_all("R3 third");
        check("R3 lock", int'(sync_state), 2);
        check("R3 num", int'(sub_num), 7);

        // R11 hold while idle
        repeat (5) @(negedge clk);
        check("R11 hold", int'(sub_num), 7);

        // R4 wrap while locked
        for (int k = 8; k < 12; k++) send_frame(k, 1);
        send_frame(0, 1);
        check("R4 wrap", int'(sub_num), 0);
        check("R4 still locked", int'(sync_state), 2);

        // R7 single bad then good; R6 counter advanced anyway
        send_frame(7, 1); check_all("R7 one bad");
        check("R7 check state", int'(sync_state), 1);
        check("R6 advanced", int'(sub_num), 1);
        send_frame(2, 1); check_all("R7 recover");
        check("R7 back", int'(sync_state), 2);

        // R8 three bads
        send_frame(9, 1); send_frame(9, 1);
        check_all("R8 two bad");
        check("R8 still locked", int'(sub_locked), 1);
        send_frame(9, 1); check_all("R8 lost");
        check("R8 search", int'(sync_state), 0);

        // R9 missing ID word
        send_frame(3, 1); send_frame(4, 1); send_frame(5, 1);
        send_frame(0, 0); check_all("R9 pre");
        send_frame(7, 1); check_all("R9 missing");
        send_frame(0, 0); send_frame(0, 0); send_frame(0, 0);
        send_frame(0, 1); check_all("R9 lost");

        // R5 out-of-range in search, R4 wrap during acquisition
        drop_frame_lock();
        send_frame(10, 1); send_frame(11, 1); send_frame(12, 1);
        check_all("R5 range");
        check("R5 no lock", int'(sub_locked), 0);
        send_frame(10, 1); send_frame(11, 1); send_frame(0, 1);
        check_all("R4 acq wrap");
        check("R4 acq num", int'(sub_num), 0);

        // R10 drop while locked
        drop_frame_lock();

        // random phase with several counts
        for (int round = 0; round < 4; round++) begin
            @(negedge clk);
            frame_locked = 1'b0;
            m_step(0, 0, 0, 0);
            @(negedge clk);
            cfg_sub_count = SUB_W'(3 + ($urandom % 20));
            frame_locked = 1'b1;
            tx = int'($urandom % int'(cfg_sub_count));
            for (int f = 0; f < 150; f++) begin
                int r;
                r = int'($urandom % 100);
                if (r < 80) send_frame(tx, 1);
                else if (r < 95) send_frame(int'($urandom % 40), 1);
                else send_frame(tx, 0);
                check_all("R6 random");
                tx = nxt(tx, int'(cfg_sub_count));
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule